// File: doc/BRIEF.md
# Two-Wire Serial-EEPROM Emulation Slave

This block sits on a two-wire serial bus as a slave and presents a 256-byte dual-port RAM to an external master as though it were a small serial EEPROM. Software fills the RAM through its own port. The master then reads it or writes it with no software work per byte. A write transfer sends the device address, then a word address, then any number of data bytes. A read transfer returns bytes starting at the current word pointer. A random read is a word-address write followed by a repeated start and a read.

The device address is held in a 7-bit register. Software picks how many of its upper bits must match, so one slave can answer a group of 2, 4 or 1 bus addresses. Each RAM half has its own write enable. A confine mode folds every access into the lower 128 bytes. The bus clock and data inputs are assumed to be already synchronized to `clk`. The output `sda_pd` drives an open-drain pull-down on the data line.

Top module: `eeslv_top`

## Requirements
- R1: After reset, `sda_pd`, `ram_we` and `ram_re` are all low.
- R2: The first byte after a start carries the device address in bits 7:1 and R/W in bit 0, with 1 meaning read. `match_w` selects the compare width: 0 compares the upper 5 bits of `own_addr`, 1 compares the upper 6 bits, and 2 or 3 compares all 7. On a match the slave pulls SDA low for the 9th clock. Otherwise it leaves SDA released and ignores the bus until the next start.
- R3: While `en` is low the slave acknowledges nothing and issues no RAM write.
- R4: In a write transfer, the first byte after the address is the word address. Each following byte is written to the RAM at the word pointer, and every byte is acknowledged.
- R5: In a read transfer, bytes come from the RAM at the word pointer, MSB first. A read with no preceding word address continues from the pointer left by the last access.
- R6: The word pointer advances by one after each data byte, read or written, and wraps from 255 to 0.
- R7: `wr_lo_en` permits writes to addresses 0..127 and `wr_hi_en` permits writes to 128..255. A data byte aimed at a protected half is still acknowledged, but the RAM is left unchanged.
- R8: While `lower_only` is high, the word address MSB is forced to 0, the pointer wraps from 127 to 0, and no RAM access reaches 128..255.
- R9: A repeated start, even in the middle of a byte, returns the slave to the address phase. A stop returns it to idle, so bits clocked after a stop without a new start get no acknowledge.
- R10: In a read, a NACK from the master ends the transfer. The slave then drives no further bits until a new start.
- R11: `ram_re` is a one-cycle strobe, and `ram_rdata` is taken the cycle after it. `ram_we` is a one-cycle strobe and never coincides with `ram_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock |
| sda_i | input | 1 | Synchronized bus data (wired line level) |
| en | input | 1 | Slave enable |
| own_addr | input | 7 | Device address |
| match_w | input | 2 | Compare width select: 0=5, 1=6, 2/3=7 bits |
| wr_lo_en | input | 1 | Write enable for the lower half |
| wr_hi_en | input | 1 | Write enable for the upper half |
| lower_only | input | 1 | Confine all accesses to the lower half |
| ram_rdata | input | 8 | RAM read data, valid one cycle after `ram_re` |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| sda_pd | output | 1 | Data-line pull-down (1 pulls SDA low) |

## Verification
At the final falling clock edge of a written data byte, two things happen in the same cycle. The RAM write strobe fires at the current pointer, and the pointer steps to its next value, which may wrap. The bench provokes this by writing two bytes starting at word address 255 in full mode. It repeats the write at word address 255 with the lower-half confine set, where the folded pointer 127 wraps to 0. It judges the result by which RAM locations changed: 255 then 0 in full mode, 127 then 0 in confine mode, with 255 untouched. Any mix-up between the write address and the advanced pointer would land a byte in the wrong place.

// File: rtl/eeslv_pkg.sv
package eeslv_pkg;
  localparam int BYTE_W = 8;
  localparam int DEV_W  = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WADR,
    ST_WDAT,
    ST_RDAT,
    ST_RACK
  } st_e;

  localparam logic [1:0] MW_5 = 2'd0;
  localparam logic [1:0] MW_6 = 2'd1;
endpackage

// File: rtl/eeslv_bus_events.sv
module eeslv_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SDA may only move with SCL high for start/stop conditions
  assign ev_start = scl_q & scl_i & sda_q & ~sda_i;
  assign ev_stop  = scl_q & scl_i & ~sda_q & sda_i;
  assign ev_rise  = ~scl_q & scl_i;
  assign ev_fall  = scl_q & ~scl_i;
endmodule

// File: rtl/eeslv_addr_match.sv
module eeslv_addr_match
  import eeslv_pkg::*;
(
  input  logic [DEV_W-1:0] own_addr,
  input  logic [DEV_W-1:0] rx_addr,
  input  logic [1:0]       match_w,
  output logic             hit
);
  logic [DEV_W-1:0] mask;

  always_comb begin
    unique case (match_w)
      MW_5:    mask = {{(DEV_W-2){1'b1}}, 2'b00};
      MW_6:    mask = {{(DEV_W-1){1'b1}}, 1'b0};
      default: mask = {DEV_W{1'b1}};
    endcase
  end

  assign hit = ((own_addr ^ rx_addr) & mask) == '0;
endmodule

// File: rtl/eeslv_ptr.sv
module eeslv_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  input  logic          half_only,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] ptr_q, ptr_n, inc_v;

  function automatic logic [AW-1:0] fold(input logic [AW-1:0] v, input logic h);
    fold = h ? {1'b0, v[AW-2:0]} : v;
  endfunction

  assign inc_v = ptr_q + 1'b1;

  always_comb begin
    ptr_n = ptr_q;
    if (load)
      ptr_n = fold(load_val, half_only);
    else if (inc)
      ptr_n = fold(inc_v, half_only);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (load || inc)
      ptr_q <= ptr_n;
  end

  assign addr = fold(ptr_q, half_only);
endmodule

// File: rtl/eeslv_top.sv
module eeslv_top
  import eeslv_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              en,
  input  logic [DEV_W-1:0]  own_addr,
  input  logic [1:0]        match_w,
  input  logic              wr_lo_en,
  input  logic              wr_hi_en,
  input  logic              lower_only,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic [AW-1:0]     ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              ram_we,
  output logic              ram_re,
  output logic              sda_pd
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(BYTE_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(BYTE_W - 1);

  st_e               st_q, st_n, ackto_q, ackto_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [BYTE_W-1:0] rx_q, rx_n, tx_q, tx_n;
  logic              aok_q, aok_n;
  logic              rdreq_q, rdreq_n;
  logic              ldp_q;
  logic              ev_start, ev_stop, ev_rise, ev_fall;
  logic              hit, p_load, p_inc, we_c, wr_ok;

  eeslv_bus_events u_ev (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .ev_start(ev_start),
    .ev_stop (ev_stop),
    .ev_rise (ev_rise),
    .ev_fall (ev_fall)
  );

  eeslv_addr_match u_match (
    .own_addr(own_addr),
    .rx_addr (rx_q[BYTE_W-1:1]),
    .match_w (match_w),
    .hit     (hit)
  );

  eeslv_ptr #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (p_load),
    .load_val (rx_q[AW-1:0]),
    .inc      (p_inc),
    .half_only(lower_only),
    .addr     (ram_addr)
  );

  assign wr_ok = ram_addr[AW-1] ? wr_hi_en : wr_lo_en;

  // next-state logic
  always_comb begin
    st_n    = st_q;
    ackto_n = ackto_q;
    cnt_n   = cnt_q;
    rx_n    = rx_q;
    tx_n    = ldp_q ? ram_rdata : tx_q;
    aok_n   = aok_q;
    rdreq_n = 1'b0;
    p_load  = 1'b0;
    p_inc   = 1'b0;
    we_c    = 1'b0;
    if (!en) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
    end else if (ev_start) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
    end else if (ev_stop) begin
      st_n  = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_WADR, ST_WDAT: begin
          if (ev_rise && cnt_q != CNT_FULL) begin
            rx_n  = {rx_q[BYTE_W-2:0], sda_i};
            cnt_n = cnt_q + 1'b1;
          end
          if (ev_fall && cnt_q == CNT_FULL) begin
            cnt_n = '0;
            if (st_q == ST_ADDR) begin
              if (hit) begin
                st_n    = ST_ACK;
                ackto_n = rx_q[0] ? ST_RDAT : ST_WADR;
                rdreq_n = rx_q[0];
              end else begin
                st_n = ST_IDLE;
              end
            end else if (st_q == ST_WADR) begin
              p_load  = 1'b1;
              st_n    = ST_ACK;
              ackto_n = ST_WDAT;
            end else begin
              we_c    = wr_ok;
              p_inc   = 1'b1;
              st_n    = ST_ACK;
              ackto_n = ST_WDAT;
            end
          end
        end
        ST_ACK: begin
          if (ev_fall) begin
            st_n  = ackto_q;
            cnt_n = '0;
          end
        end
        ST_RDAT: begin
          if (ev_fall) begin
            if (cnt_q == CNT_LAST) begin
              st_n    = ST_RACK;
              cnt_n   = '0;
              p_inc   = 1'b1;
              rdreq_n = 1'b1;
            end else begin
              tx_n  = {tx_q[BYTE_W-2:0], 1'b0};
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (ev_rise)
            aok_n = ~sda_i;
          if (ev_fall)
            st_n = aok_q ? ST_RDAT : ST_IDLE;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ackto_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      aok_q   <= 1'b0;
      rdreq_q <= 1'b0;
      ldp_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      ackto_q <= ackto_n;
      cnt_q   <= cnt_n;
      rx_q    <= rx_n;
      tx_q    <= tx_n;
      aok_q   <= aok_n;
      rdreq_q <= rdreq_n;
      ldp_q   <= rdreq_q;
    end
  end

  assign ram_wdata = rx_q;
  assign ram_we    = we_c;
  assign ram_re    = rdreq_q;
  assign sda_pd    = (st_q == ST_ACK) || (st_q == ST_RDAT && !tx_q[BYTE_W-1]);
endmodule

// File: rtl/eeslv_chk.sv
module eeslv_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          en,
  input logic          wr_lo_en,
  input logic          wr_hi_en,
  input logic          lower_only,
  input logic [AW-1:0] ram_addr,
  input logic          ram_we,
  input logic          ram_re,
  input logic          sda_pd
);
  // R3
  en_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sda_pd);

  // R7
  we_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr[AW-1] ? wr_hi_en : wr_lo_en));

  // R8
  lower_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lower_only && (ram_we || ram_re)) |-> !ram_addr[AW-1]);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re));

  // R11
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !ram_we);

  // R9
  sda_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(sda_pd)) |-> !scl_i);
endmodule

bind eeslv_top eeslv_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .en        (en),
  .wr_lo_en  (wr_lo_en),
  .wr_hi_en  (wr_hi_en),
  .lower_only(lower_only),
  .ram_addr  (ram_addr),
  .ram_we    (ram_we),
  .ram_re    (ram_re),
  .sda_pd    (sda_pd)
);

// File: tb/eeslv_top_tb.sv
module eeslv_top_tb;
  localparam int AW = 8;
  localparam int H  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic en = 1'b1;
  logic [6:0] own_addr = 7'h50;
  logic [1:0] match_w = 2'd2;
  logic wr_lo_en = 1'b1, wr_hi_en = 1'b1, lower_only = 1'b0;
  logic [7:0] ram_rdata;
  logic [AW-1:0] ram_addr;
  logic [7:0] ram_wdata;
  logic ram_we, ram_re, sda_pd, line;
  logic [7:0] ram [256];
  int n_chk = 0, n_bad = 0, we_cnt = 0, hi_touch = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign line = sda_m & ~sda_pd;

  eeslv_top #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line), .en(en),
    .own_addr(own_addr), .match_w(match_w), .wr_lo_en(wr_lo_en),
    .wr_hi_en(wr_hi_en), .lower_only(lower_only), .ram_rdata(ram_rdata),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .ram_re(ram_re), .sda_pd(sda_pd)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'(i) ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) ram[i] <= init_val(i);
      ram_rdata <= 8'h00;
    end else begin
      if (ram_we) begin
        ram[ram_addr] <= ram_wdata;
        we_cnt <= we_cnt + 1;
      end
      if (ram_re) ram_rdata <= ram[ram_addr];
      if (lower_only && (ram_we || ram_re) && ram_addr[AW-1]) hi_touch <= hi_touch + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; hp(); scl_m = 1'b1;
    repeat (H/2) @(negedge clk);
    b = line;
    repeat (H - H/2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(input logic m_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~m_ack);
  endtask

  task automatic do_write(input logic [6:0] dev, input logic [7:0] wa, input int n,
                          input logic [31:0] dat, input logic exp_ack, input string tag);
    logic a;
    bus_start();
    put_byte({dev, 1'b0}, a); chk(a == exp_ack, tag, a, exp_ack);
    put_byte(wa, a);          chk(a == exp_ack, tag, a, exp_ack);
    for (int k = 0; k < n; k++) begin
      put_byte(dat[8*k +: 8], a);
      chk(a == exp_ack, tag, a, exp_ack);
    end
    bus_stop();
  endtask

  task automatic set_ptr(input logic [7:0] wa);
    logic a;
    bus_start();
    put_byte({7'h50, 1'b0}, a);
    put_byte(wa, a);
  endtask

  task automatic do_read(input int n, output logic [31:0] got, input string tag);
    logic a;
    logic [7:0] v;
    got = '0;
    bus_start();
    put_byte({7'h50, 1'b1}, a); chk(a, tag, a, 1);
    for (int k = 0; k < n; k++) begin
      get_byte(k != n - 1, v);
      got[8*k +: 8] = v;
    end
    bus_stop();
  endtask

  task automatic probe(input logic [6:0] dev, output logic ack);
    bus_start();
    put_byte({dev, 1'b0}, ack);
    bus_stop();
  endtask

  task automatic t_reset();
    chk(!sda_pd && !ram_we && !ram_re, "R1 outputs in reset", {sda_pd, ram_we, ram_re}, 0);
    rst_n = 1'b1; hp();
    chk(!sda_pd && !ram_we && !ram_re, "R1 outputs after reset", {sda_pd, ram_we, ram_re}, 0);
  endtask

  task automatic t_write_read();
    logic [31:0] g;
    do_write(7'h50, 8'h10, 3, 32'h00C3B2A1, 1'b1, "R4 write ack");
    chk(ram[8'h10] == 8'hA1 && ram[8'h11] == 8'hB2 && ram[8'h12] == 8'hC3,
        "R4 write data", {ram[8'h10], ram[8'h11], ram[8'h12]}, 24'hA1B2C3);
    set_ptr(8'h10);
    do_read(3, g, "R5 read addr ack");
    chk(g[23:0] == 24'hC3B2A1, "R5 random read with auto-increment R11", g, 24'hC3B2A1);
    do_read(1, g, "R5 cur read ack");
    chk(g[7:0] == init_val(8'h13), "R5 R6 current-address read", g[7:0], init_val(8'h13));
  endtask

  task automatic t_match();
    logic a;
    match_w = 2'd0; probe(7'h53, a); chk(a,  "R2 5-bit match 1010011", a, 1);
    match_w = 2'd1; probe(7'h53, a); chk(!a, "R2 6-bit mismatch 1010011", a, 0);
    probe(7'h51, a);                 chk(a,  "R2 6-bit match 1010001", a, 1);
    match_w = 2'd2; probe(7'h51, a); chk(!a, "R2 7-bit mismatch 1010001", a, 0);
    probe(7'h50, a);                 chk(a,  "R2 7-bit exact match", a, 1);
  endtask

  task automatic t_enable();
    logic a;
    int w0;
    en = 1'b0;
    probe(7'h50, a); chk(!a, "R3 disabled no ack", a, 0);
    w0 = we_cnt;
    do_write(7'h50, 8'h60, 1, 32'h77, 1'b0, "R3 disabled write ack");
    chk(we_cnt == w0 && ram[8'h60] == init_val(8'h60), "R3 disabled no write", ram[8'h60], init_val(8'h60));
    en = 1'b1;
  endtask

  task automatic t_protect();
    wr_lo_en = 1'b0;
    do_write(7'h50, 8'h20, 1, 32'h11, 1'b1, "R7 protected write still acked");
    chk(ram[8'h20] == init_val(8'h20), "R7 lower protected", ram[8'h20], init_val(8'h20));
    do_write(7'h50, 8'h90, 1, 32'h22, 1'b1, "R7 upper write ack");
    chk(ram[8'h90] == 8'h22, "R7 upper writable", ram[8'h90], 8'h22);
    wr_lo_en = 1'b1; wr_hi_en = 1'b0;
    do_write(7'h50, 8'hA0, 1, 32'h33, 1'b1, "R7 protected upper ack");
    chk(ram[8'hA0] == init_val(8'hA0), "R7 upper protected", ram[8'hA0], init_val(8'hA0));
    do_write(7'h50, 8'h30, 1, 32'h44, 1'b1, "R7 lower write ack");
    chk(ram[8'h30] == 8'h44, "R7 lower writable", ram[8'h30], 8'h44);
    wr_hi_en = 1'b1;
  endtask

  task automatic t_wrap();
    logic [31:0] g;
    do_write(7'h50, 8'hFF, 2, 32'h6F5E, 1'b1, "R6 wrap write ack");
    chk(ram[8'hFF] == 8'h5E && ram[8'h00] == 8'h6F, "R6 wrap 255 to 0",
        {ram[8'hFF], ram[8'h00]}, 16'h5E6F);
    do_read(1, g, "R6 post-wrap read ack");
    chk(g[7:0] == init_val(1), "R6 pointer after wrap", g[7:0], init_val(1));
  endtask

  task automatic t_lower();
    logic [31:0] g;
    lower_only = 1'b1;
    do_write(7'h50, 8'hFF, 2, 32'h7271, 1'b1, "R8 confined write ack");
    chk(ram[8'h7F] == 8'h71 && ram[8'h00] == 8'h72 && ram[8'hFF] == 8'h5E,
        "R8 fold and wrap 127 to 0", {ram[8'h7F], ram[8'h00], ram[8'hFF]}, 24'h71725E);
    set_ptr(8'h85);
    do_read(1, g, "R8 confined read ack");
    chk(g[7:0] == init_val(5), "R8 folded read address", g[7:0], init_val(5));
    chk(hi_touch == 0, "R8 no upper access", hi_touch, 0);
    lower_only = 1'b0;
  endtask

  task automatic t_rstart_stop();
    logic a, b;
    logic [31:0] g;
    bus_start();
    put_byte({7'h50, 1'b0}, a);
    put_byte(8'h40, a);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    set_ptr(8'h40);
    do_read(1, g, "R9 read after repeated start ack");
    chk(g[7:0] == init_val(8'h40) && ram[8'h40] == init_val(8'h40),
        "R9 repeated start mid-byte", g[7:0], init_val(8'h40));
    scl_m = 1'b0; hp();
    for (int i = 7; i >= 0; i--) put_bit(i == 0 ? 1'b0 : 7'h50 >> (i - 1));
    get_bit(b);
    chk(b == 1'b1, "R9 no ack after stop without start", ~b, 0);
    bus_stop();
  endtask

  task automatic t_nack();
    logic a;
    logic [7:0] v, w;
    logic b;
    set_ptr(8'h10);
    bus_start();
    put_byte({7'h50, 1'b1}, a);
    get_byte(1'b0, v);
    chk(v == 8'hA1, "R10 byte before nack", v, 8'hA1);
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      w[i] = b;
    end
    get_bit(b);
    chk(w == 8'hFF && b, "R10 bus released after nack", {w, b}, 9'h1FF);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    t_write_read();
    t_match();
    t_enable();
    t_protect();
    t_wrap();
    t_lower();
    t_rstart_stop();
    t_nack();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule